// File: doc/BRIEF.md
# I2C SCL High/Low Count Calculator

This block turns a reference clock rate and a set of bus timing targets into the two
period counts that an I2C master's SCL generator loads: one count for the high phase
and one for the low phase. The reference rate is given in kHz. All times are given in
tenths of a microsecond. Each count is the number of reference cycles that covers the
target time, rounded to the nearest cycle. A fixed correction is then subtracted, and
a signed trim offset is added.

A calculation starts with a one-cycle `start_i` pulse and ends with a one-cycle
`done_o` pulse. Between the two, a shared restoring divider works one quotient bit
per clock: first on the high-phase numerator, then on the low-phase numerator.

Built-in presets supply the timing targets for standard mode and fast mode. When a
preset is selected, the manual time inputs are not used. Both results are clamped to
the 16-bit register range, so a negative or oversized value never wraps.

Top module: `scl_count_calc`

## Requirements
- R1: Every count is based on the rounded cycle figure floor((ref_khz_i × t + 5000) / 10000), where t is the relevant time in tenths of a microsecond.
- R2: With ideal_mode_i = 0, hcnt_o = rounded cycles for (high time + fall time) − 3 + offset_i.
- R3: With ideal_mode_i = 1, hcnt_o = rounded cycles for the high time alone − 8 + offset_i. The fall time is not used.
- R4: lcnt_o = rounded cycles for (low time + fall time) − 1 + offset_i, in both high-count modes.
- R5: With preset_en_i = 1, the block uses fixed targets and ignores t_high_i, t_low_i and t_fall_i. For fast_sel_i = 0 (standard mode) the high time is 40 and the low time is 47. For fast_sel_i = 1 (fast mode) they are 6 and 13. The fall time is 3 in both cases.
- R6: Each result is clamped to the range 0 to 65535. A value below 0 gives 0, and a value above 65535 gives 65535.
- R7: A start_i pulse while busy_o is low is accepted, and busy_o is high in the next cycle. At the end of the calculation, done_o is high for exactly one cycle. In that cycle busy_o is low and both new counts are visible. The counts then hold until the next done_o.
- R8: A start_i pulse while busy_o is high is ignored. The running calculation finishes with its original operands, and only one done_o pulse follows.
- R9: While reset is asserted, and in the cycle after it, busy_o and done_o are low and both counts are 0.
- R10: A start_i pulse in the same cycle as done_o is accepted and begins a new calculation. The counts from the finished calculation remain readable until the new done_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Calculation request pulse |
| ref_khz_i | input | 20 | Reference clock rate in kHz |
| preset_en_i | input | 1 | 1: use built-in timing targets |
| fast_sel_i | input | 1 | Preset select: 0 standard mode, 1 fast mode |
| t_high_i | input | 8 | Manual high / start-hold time, 0.1 µs units |
| t_low_i | input | 8 | Manual low time, 0.1 µs units |
| t_fall_i | input | 8 | Manual SCL fall time, 0.1 µs units |
| ideal_mode_i | input | 1 | 1: ideal high-count rule (−8), 0: default rule (−3, fall time added) |
| offset_i | input | 16 | Signed trim added to both counts |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hcnt_o | output | 16 | High-phase count result |
| lcnt_o | output | 16 | Low-phase count result |

## Verification
Two functions can fall in the same cycle: the acceptance of a new request and the completion pulse of the previous one. There is also the related case of a request that arrives while a calculation is still running. The bench raises start_i in the very cycle where it sees done_o. It then checks that the counts for the finished operands are still on the outputs, that busy_o rises in the next cycle, and that the later done_o carries the counts for the new operands. For the busy case, it changes the operands and pulses start_i partway through a calculation. It then checks that exactly one done_o follows, that it carries the counts for the original operands, and that no extra pulse appears afterwards.

// File: rtl/scl_calc_pkg.sv
package scl_calc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_H,
    ST_RUN_H,
    ST_LOAD_L,
    ST_RUN_L
  } calc_state_t;

  // preset timing targets, tenths of a microsecond
  localparam int STD_HIGH_T  = 40;
  localparam int STD_LOW_T   = 47;
  localparam int FAST_HIGH_T = 6;
  localparam int FAST_LOW_T  = 13;
  localparam int PRESET_FALL = 3;

  // fixed subtractions per formula
  localparam int SUB_HIGH_DEFAULT = 3;
  localparam int SUB_HIGH_IDEAL   = 8;
  localparam int SUB_LOW          = 1;
  localparam int SUB_W            = 4;

  // tenths of a microsecond times kHz -> cycles scale
  localparam int TIME_SCALE = 10000;

endpackage

// File: rtl/scl_calc_operands.sv
module scl_calc_operands
  import scl_calc_pkg::*;
#(
  parameter int KHZ_W = 20,
  parameter int T_W   = 8,
  parameter int NUM_W = KHZ_W + T_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [KHZ_W-1:0] khz,
  input  logic             preset_en,
  input  logic             fast_sel,
  input  logic [T_W-1:0]   t_high,
  input  logic [T_W-1:0]   t_low,
  input  logic [T_W-1:0]   t_fall,
  input  logic             ideal,
  output logic [NUM_W-1:0] h_num,
  output logic [NUM_W-1:0] l_num
);

  localparam int HALF = TIME_SCALE / 2;

  logic [T_W-1:0] sel_high, sel_low, sel_fall;
  logic [T_W:0]   h_time, l_time;
  logic [NUM_W-1:0] h_prod, l_prod;

  always_comb begin
    if (preset_en) begin
      sel_high = fast_sel ? T_W'(FAST_HIGH_T) : T_W'(STD_HIGH_T);
      sel_low  = fast_sel ? T_W'(FAST_LOW_T)  : T_W'(STD_LOW_T);
      sel_fall = T_W'(PRESET_FALL);
    end else begin
      sel_high = t_high;
      sel_low  = t_low;
      sel_fall = t_fall;
    end
    h_time = ideal ? {1'b0, sel_high} : ({1'b0, sel_high} + {1'b0, sel_fall});
    l_time = {1'b0, sel_low} + {1'b0, sel_fall};
    h_prod = NUM_W'(khz) * NUM_W'(h_time);
    l_prod = NUM_W'(khz) * NUM_W'(l_time);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_num <= '0;
      l_num <= '0;
    end else if (load) begin
      h_num <= h_prod + NUM_W'(HALF);
      l_num <= l_prod + NUM_W'(HALF);
    end
  end

endmodule

// File: rtl/scl_calc_divider.sv
module scl_calc_divider #(
  parameter int NUM_W   = 30,
  parameter int DIVISOR = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  output logic [NUM_W-1:0] quo,
  output logic             valid
);

  localparam int R_W = $clog2(DIVISOR) + 1;
  localparam int C_W = $clog2(NUM_W + 1);
  localparam logic [R_W-1:0] DVS = R_W'(DIVISOR);

  logic [R_W-1:0] rem;
  logic [C_W-1:0] cnt;
  logic           run;
  logic [R_W-1:0] shifted;
  logic [R_W-1:0] diff;
  logic           borrow;

  always_comb begin
    shifted        = {rem[R_W-2:0], quo[NUM_W-1]};
    {borrow, diff} = {1'b0, shifted} - {1'b0, DVS};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      quo   <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        rem <= '0;
        quo <= num;
        cnt <= C_W'(NUM_W);
        run <= 1'b1;
      end else if (run) begin
        rem <= borrow ? shifted : diff;
        quo <= {quo[NUM_W-2:0], ~borrow};
        cnt <= cnt - 1'b1;
        if (cnt == C_W'(1)) begin
          run   <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/scl_calc_clamp.sv
module scl_calc_clamp
  import scl_calc_pkg::*;
#(
  parameter int Q_W   = 30,
  parameter int OFS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic [Q_W-1:0]          quo,
  input  logic [SUB_W-1:0]        sub,
  input  logic signed [OFS_W-1:0] ofs,
  output logic [CNT_W-1:0]        cnt
);

  localparam int SW = ((Q_W > OFS_W) ? Q_W : OFS_W) + 3;
  localparam logic signed [SW-1:0] MAXS = SW'((64'd1 << CNT_W) - 64'd1);

  logic signed [SW-1:0] q_ext, o_ext, s_ext, v;

  always_comb begin
    q_ext = $signed({{(SW-Q_W){1'b0}}, quo});
    o_ext = $signed({{(SW-OFS_W){ofs[OFS_W-1]}}, ofs});
    s_ext = $signed({{(SW-SUB_W){1'b0}}, sub});
    v     = q_ext - s_ext + o_ext;
    if (v[SW-1])       cnt = '0;
    else if (v > MAXS) cnt = '1;
    else               cnt = v[CNT_W-1:0];
  end

endmodule

// File: rtl/scl_count_calc.sv
module scl_count_calc
  import scl_calc_pkg::*;
#(
  parameter int KHZ_W = 20,
  parameter int T_W   = 8,
  parameter int OFS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [KHZ_W-1:0]        ref_khz_i,
  input  logic                    preset_en_i,
  input  logic                    fast_sel_i,
  input  logic [T_W-1:0]          t_high_i,
  input  logic [T_W-1:0]          t_low_i,
  input  logic [T_W-1:0]          t_fall_i,
  input  logic                    ideal_mode_i,
  input  logic signed [OFS_W-1:0] offset_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [CNT_W-1:0]        hcnt_o,
  output logic [CNT_W-1:0]        lcnt_o
);

  localparam int NUM_W = KHZ_W + T_W + 2;

  calc_state_t state;
  logic accept;
  logic [NUM_W-1:0] h_num, l_num, div_num, div_quo, h_quo;
  logic div_go, div_valid;
  logic [SUB_W-1:0] h_sub;
  logic signed [OFS_W-1:0] ofs_q;
  logic [CNT_W-1:0] h_cnt_c, l_cnt_c;

  assign busy_o = (state != ST_IDLE);
  assign accept = start_i && (state == ST_IDLE);
  assign div_go  = (state == ST_LOAD_H) || (state == ST_LOAD_L);
  assign div_num = (state == ST_LOAD_H) ? h_num : l_num;

  scl_calc_operands #(.KHZ_W(KHZ_W), .T_W(T_W), .NUM_W(NUM_W)) u_ops (
    .clk(clk), .rst(rst), .load(accept), .khz(ref_khz_i),
    .preset_en(preset_en_i), .fast_sel(fast_sel_i),
    .t_high(t_high_i), .t_low(t_low_i), .t_fall(t_fall_i),
    .ideal(ideal_mode_i), .h_num(h_num), .l_num(l_num)
  );

  scl_calc_divider #(.NUM_W(NUM_W), .DIVISOR(TIME_SCALE)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .num(div_num),
    .quo(div_quo), .valid(div_valid)
  );

  scl_calc_clamp #(.Q_W(NUM_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_clamp_h (
    .quo(h_quo), .sub(h_sub), .ofs(ofs_q), .cnt(h_cnt_c)
  );

  scl_calc_clamp #(.Q_W(NUM_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_clamp_l (
    .quo(div_quo), .sub(SUB_W'(SUB_LOW)), .ofs(ofs_q), .cnt(l_cnt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      done_o <= 1'b0;
      hcnt_o <= '0;
      lcnt_o <= '0;
      h_quo  <= '0;
      h_sub  <= '0;
      ofs_q  <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          h_sub <= ideal_mode_i ? SUB_W'(SUB_HIGH_IDEAL) : SUB_W'(SUB_HIGH_DEFAULT);
          ofs_q <= offset_i;
          state <= ST_LOAD_H;
        end
        ST_LOAD_H: state <= ST_RUN_H;
        ST_RUN_H: if (div_valid) begin
          h_quo <= div_quo;
          state <= ST_LOAD_L;
        end
        ST_LOAD_L: state <= ST_RUN_L;
        ST_RUN_L: if (div_valid) begin
          hcnt_o <= h_cnt_c;
          lcnt_o <= l_cnt_c;
          done_o <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scl_count_calc_checker.sv
module scl_count_calc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] hcnt_o,
  input logic [CNT_W-1:0] lcnt_o
);

  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && hcnt_o == '0 && lcnt_o == '0));

  a_r7_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  a_r8_busy_until_done: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o));

  a_r7_hold_hcnt: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> (done_o || $stable(hcnt_o)));

  a_r7_hold_lcnt: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> (done_o || $stable(lcnt_o)));

endmodule

bind scl_count_calc scl_count_calc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .hcnt_o(hcnt_o), .lcnt_o(lcnt_o)
);

// File: tb/scl_count_calc_bench.sv
module scl_count_calc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_MAX   = 300;

  logic clk = 1'b0;
  logic rst;
  logic start_i;
  logic [19:0] ref_khz_i;
  logic preset_en_i, fast_sel_i, ideal_mode_i;
  logic [7:0] t_high_i, t_low_i, t_fall_i;
  logic signed [15:0] offset_i;
  logic busy_o, done_o;
  logic [15:0] hcnt_o, lcnt_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_count_calc u_scl_count_calc (
    .clk(clk), .rst(rst), .start_i(start_i), .ref_khz_i(ref_khz_i),
    .preset_en_i(preset_en_i), .fast_sel_i(fast_sel_i),
    .t_high_i(t_high_i), .t_low_i(t_low_i), .t_fall_i(t_fall_i),
    .ideal_mode_i(ideal_mode_i), .offset_i(offset_i),
    .busy_o(busy_o), .done_o(done_o), .hcnt_o(hcnt_o), .lcnt_o(lcnt_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog R7 actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic longint rcyc(longint khz, longint t);
    return (khz * t + 5000) / 10000;
  endfunction

  function automatic longint clampv(longint v);
    if (v < 0) return 0;
    if (v > 65535) return 65535;
    return v;
  endfunction

  // expected high and low counts from the requirement formulas
  function automatic longint exp_h(longint khz, int th, int tf, bit ideal, int ofs);
    if (ideal) return clampv(rcyc(khz, th) - 8 + ofs);
    return clampv(rcyc(khz, th + tf) - 3 + ofs);
  endfunction

  function automatic longint exp_l(longint khz, int tl, int tf, int ofs);
    return clampv(rcyc(khz, tl + tf) - 1 + ofs);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_ops(int khz, bit pre, bit fast, int th, int tl, int tf,
                         bit ideal, int ofs);
    ref_khz_i = 20'(khz); preset_en_i = pre; fast_sel_i = fast;
    t_high_i = 8'(th); t_low_i = 8'(tl); t_fall_i = 8'(tf);
    ideal_mode_i = ideal; offset_i = 16'(ofs);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // waits at negedges until done_o is seen; returns with the done cycle sampled
  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < WAIT_MAX; i++) begin
      if (done_o) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_and_check(string tag, int khz, bit pre, bit fast, int th,
                               int tl, int tf, bit ideal, int ofs);
    bit seen;
    set_ops(khz, pre, fast, th, tl, tf, ideal, ofs);
    pulse_start();
    chk({tag, " R7 busy after start"}, busy_o, 1);
    wait_done(seen);
    chk({tag, " R7 done seen"}, seen, 1);
    chk({tag, " R7 busy low at done"}, busy_o, 0);
    if (pre) begin
      th = fast ? 6 : 40; tl = fast ? 13 : 47; tf = 3;
    end
    chk({tag, " hcnt"}, hcnt_o, exp_h(khz, th, tf, ideal, ofs));
    chk({tag, " R4 lcnt"}, lcnt_o, exp_l(khz, tl, tf, ofs));
    @(negedge clk);
    chk({tag, " R7 done single cycle"}, done_o, 0);
  endtask

  task automatic t_reset();
    chk("R9 busy in reset", busy_o, 0);
    chk("R9 done in reset", done_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 busy after reset", busy_o, 0);
    chk("R9 hcnt after reset", hcnt_o, 0);
    chk("R9 lcnt after reset", lcnt_o, 0);
  endtask

  task automatic t_presets();
    // R5: manual time inputs hold junk and must be ignored
    run_and_check("R5 std R2", 100000, 1, 0, 200, 200, 200, 0, 0);
    chk("R5 std hcnt value", hcnt_o, 427);
    chk("R5 std lcnt value", lcnt_o, 499);
    run_and_check("R5 fast R3", 100000, 1, 1, 99, 99, 99, 1, 0);
    chk("R5 fast hcnt value", hcnt_o, 52);
    chk("R5 fast lcnt value", lcnt_o, 159);
  endtask

  task automatic t_manual();
    run_and_check("R1 round R2", 12345, 0, 0, 40, 47, 3, 0, 0);
    run_and_check("R1 round up R2", 15000, 0, 0, 33, 21, 4, 0, 0);
    run_and_check("R3 ideal ignores tf", 50000, 0, 0, 20, 30, 250, 1, 0);
    run_and_check("R2 pos offset", 33333, 0, 0, 13, 17, 2, 0, 25);
    run_and_check("R4 neg offset", 400000, 0, 0, 6, 13, 3, 0, -40);
  endtask

  task automatic t_saturate();
    run_and_check("R6 low clamp R3", 1000, 0, 0, 6, 2, 0, 1, -5);
    chk("R6 hcnt zero", hcnt_o, 0);
    chk("R6 lcnt zero", lcnt_o, 0);
    run_and_check("R6 high clamp", 1048575, 0, 0, 255, 255, 255, 0, 32767);
    chk("R6 hcnt max", hcnt_o, 65535);
    chk("R6 lcnt max", lcnt_o, 65535);
  endtask

  task automatic t_busy_ignore();
    bit seen;
    set_ops(100000, 0, 0, 40, 47, 3, 0, 0);
    pulse_start();
    repeat (5) @(negedge clk);
    set_ops(20000, 0, 0, 10, 10, 1, 1, 7);
    pulse_start();
    chk("R8 still busy", busy_o, 1);
    wait_done(seen);
    chk("R8 done seen", seen, 1);
    chk("R8 hcnt from first operands", hcnt_o, exp_h(100000, 40, 3, 0, 0));
    chk("R8 lcnt from first operands", lcnt_o, exp_l(100000, 47, 3, 0));
    @(negedge clk);
    seen = 1'b0;
    for (int i = 0; i < 150; i++) begin
      if (done_o || busy_o) seen = 1'b1;
      @(negedge clk);
    end
    chk("R8 no second calculation", seen, 0);
  endtask

  task automatic t_start_on_done();
    bit seen;
    set_ops(75000, 0, 0, 12, 18, 3, 0, 3);
    pulse_start();
    wait_done(seen);
    chk("R10 first done", seen, 1);
    set_ops(25000, 1, 1, 0, 0, 0, 1, 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10 accepted busy", busy_o, 1);
    chk("R10 old hcnt held", hcnt_o, exp_h(75000, 12, 3, 0, 3));
    chk("R10 old lcnt held", lcnt_o, exp_l(75000, 18, 3, 3));
    wait_done(seen);
    chk("R10 second done", seen, 1);
    chk("R10 new hcnt", hcnt_o, exp_h(25000, 6, 3, 1, 0));
    chk("R10 new lcnt", lcnt_o, exp_l(25000, 13, 3, 0));
  endtask

  initial begin
    rst = 1'b1;
    start_i = 1'b0;
    set_ops(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    t_presets();
    t_manual();
    t_saturate();
    t_busy_ignore();
    t_start_on_done();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule